// File: doc/BRIEF.md
# Prioritised Edge/Level Interrupt Handler

This block gathers 32 interrupt request lines and presents them to a processor as two outputs: a normal request and a fast request. Each line is set up through its own configuration word. That word chooses whether the line is event-type (an assertion is remembered until it is serviced) or level-type (the request follows the input). It also selects the output class and gives the line a 5-bit priority. Software reaches the block through a simple word-wide register port. The port has a valid strobe, a write flag, a byte address and 32-bit data. Read data is returned combinationally in the same cycle as the request.

Each output works as a one-shot handshake. When its class has an unmasked pending line and its agreement flag is armed, the output rises, the flag disarms, and the number of the winning line is captured in that class's code register. The output then stays high until software writes the matching bit of the control register. That write drops the output and re-arms the flag. Reading a code register also services an event-type line by clearing its pending bit. A trigger register lets software inject an assertion on one line.

Top module: `edge_level_intc`

## Requirements
- R1: After reset the mask register reads 0xFFFFFFFF. The pending register and both code registers read 0, both outputs are low, and every line's configuration reads 0.
- R2: On an event-type line (configuration bit 1 = 0), a 0-to-1 change of the input sets the pending bit. The bit stays set after the input returns to 0.
- R3: On a level-type line (configuration bit 1 = 1), the pending bit is cleared in the cycle after the input returns to 0.
- R4: A write to the pending register (offset 0x00) ANDs the written value into the pending bits. Pending bits of level-type lines whose input is still high are kept.
- R5: An output rises only when its agreement is armed and an unmasked pending line of its class exists. Configuration bit 0 picks the class: 0 = normal output, 1 = fast output.
- R6: The raised output latches the winning line number into its code register (normal at 0x10, fast at 0x14). The winner is the line with the smallest priority value. A tie goes to the higher line number.
- R7: Reading a code register clears the pending bit of the latched line if that line is event-type. A level-type line's pending bit is left unchanged by the read.
- R8: A raised output stays high until a write to the control register (0x18) with bit 0 (normal) or bit 1 (fast) set. That write drops the output and re-arms it. If work remains, the output rises again on the following cycle.
- R9: A write to the trigger register (0x9C) sets the pending bit of only the lowest set bit of the written value. A written value of 0 does nothing.
- R10: The configuration word of line n lives at 0x1C + 4n. Bits [6:2] hold the priority, bit 1 the sensitivity and bit 0 the class. Other written bits are dropped and read back as 0.
- R11: Reads of offsets that are not mapped, including misaligned offsets, return 0. Writes to the code registers change nothing.
- R12: Masked lines (mask bit = 1, offset 0x04) never raise an output. A mask write that unmasks a pending line raises its output on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 32 | Interrupt request lines, 1 = asserted |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read |
| irq_o | output | 1 | Normal-class interrupt output |
| fiq_o | output | 1 | Fast-class interrupt output |

## Verification
The assertions take a few things for granted about the inputs. Each register access is a single-cycle pulse on bus_valid. Lines only change at the clock. A level-type line is not reconfigured in the same cycle as its release or a pending write. The stimulus respects all of these: every input changes on the falling edge, every access lasts one cycle, and configuration writes are always separate from request traffic on the same line. Reads are compared against values computed from the register rules while the access is still held on the port.

// File: rtl/eli_pkg.sv
package eli_pkg;
    localparam int LINES  = 32;
    localparam int PRIO_W = 5;
    localparam int ID_W   = $clog2(LINES);
    localparam int DW     = 32;
    localparam int AW     = 8;
    localparam int NCLS   = 2;

    localparam logic [AW-1:0] OFS_PEND   = 8'h00;
    localparam logic [AW-1:0] OFS_MASK   = 8'h04;
    localparam logic [AW-1:0] OFS_CODE_N = 8'h10;
    localparam logic [AW-1:0] OFS_CODE_F = 8'h14;
    localparam logic [AW-1:0] OFS_CTRL   = 8'h18;
    localparam logic [AW-1:0] OFS_CFG0   = 8'h1C;
    localparam logic [AW-1:0] OFS_TRIG   = 8'h9C;

    typedef enum logic { SENSE_EDGE = 1'b0, SENSE_LEVEL = 1'b1 } sense_e;
    typedef enum logic { CLS_NORM = 1'b0, CLS_FAST = 1'b1 } cls_e;

    // packed so that prio lands in [6:2], sense in [1], class in [0]
    typedef struct packed {
        logic [PRIO_W-1:0] prio;
        sense_e            sense;
        cls_e              cls;
    } line_cfg_t;

    localparam int CFG_W = $bits(line_cfg_t);

    function automatic line_cfg_t cfg_unpack(input logic [DW-1:0] w);
        return line_cfg_t'(w[CFG_W-1:0]);
    endfunction

    function automatic logic [DW-1:0] cfg_pack(input line_cfg_t c);
        return {{(DW-CFG_W){1'b0}}, c};
    endfunction

    // isolates the least significant set bit
    function automatic logic [LINES-1:0] lowest_bit(input logic [LINES-1:0] v);
        return v & (~v + 1'b1);
    endfunction
endpackage

// File: rtl/eli_pick.sv
module eli_pick #(
    parameter int N  = 32,
    parameter int PW = 5,
    parameter int IW = $clog2(N)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N-1:0]       req,
    input  logic [N-1:0][PW-1:0] prio,
    output logic [IW-1:0]      win,
    output logic               any
);
    logic [PW-1:0] best;
    logic          found;

    // scan upward; "<=" lets a later (higher) line win a tie
    always_comb begin
        best  = '0;
        found = 1'b0;
        win   = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && (!found || prio[i] <= best)) begin
                found = 1'b1;
                best  = prio[i];
                win   = IW'(i);
            end
        end
    end

    assign any = |req;

    AST_WIN_PENDING: assert property (@(posedge clk) disable iff (rst) any |-> req[win]);  // R6
endmodule

// File: rtl/eli_class_out.sv
module eli_class_out #(
    parameter int IW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          any,
    input  logic [IW-1:0] win,
    input  logic          rearm,
    output logic          out,
    output logic [IW-1:0] code
);
    logic armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            out     <= 1'b0;
            armed_q <= 1'b1;
            code    <= '0;
        end else if (rearm) begin
            out     <= 1'b0;
            armed_q <= 1'b1;
        end else if (armed_q && any) begin
            out     <= 1'b1;
            armed_q <= 1'b0;
            code    <= win;
        end
    end

    AST_RAISE_ARMED: assert property (@(posedge clk) disable iff (rst) $rose(out) |-> ($past(armed_q) && $past(any)));  // R5
    AST_OUT_HELD:    assert property (@(posedge clk) disable iff (rst) (out && !rearm) |=> out);                      // R8
    AST_REARM_DROP:  assert property (@(posedge clk) disable iff (rst) rearm |=> !out);                               // R8
endmodule

// File: rtl/edge_level_intc.sv
module edge_level_intc
    import eli_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] src_i,
    input  logic             bus_valid,
    input  logic             bus_write,
    input  logic [AW-1:0]    bus_addr,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    output logic             irq_o,
    output logic             fiq_o
);
    localparam int            CFG_BASE_IDX = int'(OFS_CFG0) >> 2;
    localparam logic [AW-1:0] OFS_CFG_LAST = OFS_CFG0 + AW'(4 * (LINES - 1));

    logic wr_en, rd_en;
    logic hit_pend, hit_mask, hit_code_n, hit_code_f, hit_ctrl, hit_trig, hit_cfg;
    logic [ID_W-1:0] cfg_idx;

    line_cfg_t cfg_q [LINES];
    logic [LINES-1:0] pend_q, mask_q, in_q;
    logic [LINES-1:0] lvl_v, fast_v, inj_v, rise_v, rel_v, ack_v, keep_v;
    logic [LINES-1:0][PRIO_W-1:0] prio_v;

    logic [NCLS-1:0][LINES-1:0] req_c;
    logic [NCLS-1:0][ID_W-1:0]  win_c, code_c;
    logic [NCLS-1:0]            any_c, out_c, rearm_c;
    logic [DW-1:0]              rd_word;

    // ---------------- address decode ----------------
    assign wr_en      = bus_valid &&  bus_write;
    assign rd_en      = bus_valid && !bus_write;
    assign hit_pend   = (bus_addr == OFS_PEND);
    assign hit_mask   = (bus_addr == OFS_MASK);
    assign hit_code_n = (bus_addr == OFS_CODE_N);
    assign hit_code_f = (bus_addr == OFS_CODE_F);
    assign hit_ctrl   = (bus_addr == OFS_CTRL);
    assign hit_trig   = (bus_addr == OFS_TRIG);
    assign hit_cfg    = (bus_addr >= OFS_CFG0) && (bus_addr <= OFS_CFG_LAST) && (bus_addr[1:0] == 2'b00);
    assign cfg_idx    = bus_addr[ID_W+1:2] - ID_W'(CFG_BASE_IDX);

    // ---------------- per-line configuration ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LINES; i++) cfg_q[i] <= '0;
        end else if (wr_en && hit_cfg) begin
            cfg_q[cfg_idx] <= cfg_unpack(bus_wdata);
        end
    end

    for (genvar i = 0; i < LINES; i++) begin : g_line
        assign lvl_v[i]  = (cfg_q[i].sense == SENSE_LEVEL);
        assign fast_v[i] = (cfg_q[i].cls == CLS_FAST);
        assign prio_v[i] = cfg_q[i].prio;

        AST_LEVEL_RELEASE: assert property (@(posedge clk) disable iff (rst)
            (lvl_v[i] && in_q[i] && !src_i[i] && !inj_v[i]) |=> !pend_q[i]);  // R3
        AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (rst)
            (!lvl_v[i] && pend_q[i] && !ack_v[i] && !(wr_en && hit_pend && !bus_wdata[i])) |=> pend_q[i]);  // R2
        AST_LEVEL_GUARD: assert property (@(posedge clk) disable iff (rst)
            (lvl_v[i] && pend_q[i] && in_q[i] && src_i[i] && wr_en && hit_pend) |=> pend_q[i]);  // R4
    end

    // ---------------- pending state ----------------
    assign inj_v  = (wr_en && hit_trig) ? lowest_bit(bus_wdata[LINES-1:0]) : '0;
    assign rise_v = (src_i & ~in_q) | inj_v;
    assign rel_v  = in_q & ~src_i & ~inj_v;
    assign keep_v = (wr_en && hit_pend) ? (bus_wdata[LINES-1:0] | (lvl_v & in_q)) : '1;

    always_comb begin
        ack_v = '0;
        if (rd_en && hit_code_n) ack_v[code_c[0]] = 1'b1;
        if (rd_en && hit_code_f) ack_v[code_c[1]] = 1'b1;
        ack_v = ack_v & ~lvl_v;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            in_q   <= '0;
            mask_q <= '1;
        end else begin
            pend_q <= (pend_q & ~(rel_v & lvl_v) & ~ack_v & keep_v) | rise_v;
            in_q   <= src_i | inj_v;
            if (wr_en && hit_mask) mask_q <= bus_wdata[LINES-1:0];
        end
    end

    AST_TRIG_SINGLE: assert property (@(posedge clk) disable iff (rst) $onehot0(inj_v));  // R9

    // ---------------- per-class arbitration and output ----------------
    for (genvar c = 0; c < NCLS; c++) begin : g_cls
        assign req_c[c]   = pend_q & ~mask_q & ((c == 1) ? fast_v : ~fast_v);
        assign rearm_c[c] = wr_en && hit_ctrl && bus_wdata[c];

        eli_pick #(.N(LINES), .PW(PRIO_W), .IW(ID_W)) u_pick (
            .clk  (clk),
            .rst  (rst),
            .req  (req_c[c]),
            .prio (prio_v),
            .win  (win_c[c]),
            .any  (any_c[c])
        );

        eli_class_out #(.IW(ID_W)) u_out (
            .clk   (clk),
            .rst   (rst),
            .any   (any_c[c]),
            .win   (win_c[c]),
            .rearm (rearm_c[c]),
            .out   (out_c[c]),
            .code  (code_c[c])
        );
    end

    assign irq_o = out_c[0];
    assign fiq_o = out_c[1];

    // ---------------- read path ----------------
    always_comb begin
        rd_word = '0;
        if (hit_pend)        rd_word = DW'(pend_q);
        else if (hit_mask)   rd_word = DW'(mask_q);
        else if (hit_code_n) rd_word = DW'(code_c[0]);
        else if (hit_code_f) rd_word = DW'(code_c[1]);
        else if (hit_cfg)    rd_word = cfg_pack(cfg_q[cfg_idx]);
        bus_rdata = rd_en ? rd_word : '0;
    end
endmodule

// File: tb/edge_level_intc_tb.sv
module edge_level_intc_tb;
    localparam int CLK_PERIOD = 10;

    localparam logic [7:0] A_PEND = 8'h00, A_MASK = 8'h04, A_CODE_N = 8'h10,
                           A_CODE_F = 8'h14, A_CTRL = 8'h18, A_TRIG = 8'h9C;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] src_i = '0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o, fiq_o;

    int total = 0;
    int bad   = 0;

    typedef struct {
        string       tag;
        logic [31:0] val;
    } exp_t;
    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    edge_level_intc u_dut (
        .clk(clk), .rst(rst), .src_i(src_i),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .fiq_o(fiq_o)
    );

    function automatic logic [7:0] cfg_a(input int n);
        return 8'(8'h1C + 4 * n);
    endfunction

    function automatic logic [31:0] cfgw(input int prio, input bit lvl, input bit fast);
        return 32'((prio << 2) | (int'(lvl) << 1) | int'(fast));
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        exp_t item;
        item.tag = tag;
        item.val = e;
        exp_q.push_back(item);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: compares read data while the access is held on the port
    always begin
        @(negedge clk);
        #(CLK_PERIOD/4);
        if (bus_valid && !bus_write) begin
            total++;
            if (exp_q.size() == 0) begin
                bad++;
                $display("FAIL scoreboard empty actual=%0h expected=none", bus_rdata);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (bus_rdata !== e.val) begin
                    bad++;
                    $display("FAIL %s actual=%0h expected=%0h", e.tag, bus_rdata, e.val);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        tick(3);
        rst = 1'b0;
        tick(1);

        // R1 reset state
        bus_rd(A_PEND, 32'h0, "R1 pending");
        bus_rd(A_MASK, 32'hFFFF_FFFF, "R1 mask");
        bus_rd(A_CODE_N, 32'h0, "R1 code normal");
        bus_rd(A_CODE_F, 32'h0, "R1 code fast");
        bus_rd(cfg_a(9), 32'h0, "R1 cfg");
        chk("R1 irq", {31'b0, irq_o}, 32'h0);
        chk("R1 fiq", {31'b0, fiq_o}, 32'h0);

        // R10 configuration layout
        bus_wr(cfg_a(5), cfgw(3, 1'b1, 1'b0));
        bus_rd(cfg_a(5), 32'h0E, "R10 cfg5");
        bus_wr(cfg_a(31), 32'h7F);
        bus_rd(cfg_a(31), 32'h7F, "R10 cfg31");
        bus_wr(cfg_a(2), 32'hFFFF_FF81);
        bus_rd(cfg_a(2), 32'h01, "R10 dropped bits");
        bus_wr(cfg_a(31), 32'h0);
        bus_wr(cfg_a(2), 32'h0);
        bus_wr(cfg_a(5), 32'h0);

        // R2 event line sticks; R12 masked line stays quiet
        src_i[3] = 1'b1; tick(1);
        src_i[3] = 1'b0; tick(1);
        bus_rd(A_PEND, 32'h8, "R2 sticky");
        chk("R12 masked quiet", {31'b0, irq_o}, 32'h0);

        // R12 unmask raises on the next cycle
        bus_wr(A_MASK, 32'hFFFF_FFF7);
        chk("R12 not yet", {31'b0, irq_o}, 32'h0);
        tick(1);
        chk("R12 raised", {31'b0, irq_o}, 32'h1);
        chk("R5 fast idle", {31'b0, fiq_o}, 32'h0);

        // R6 code, R7 event ack, R8 hold
        bus_rd(A_CODE_N, 32'd3, "R6 code");
        bus_rd(A_PEND, 32'h0, "R7 event ack");
        chk("R8 held", {31'b0, irq_o}, 32'h1);
        bus_wr(A_CTRL, 32'h1);
        tick(2);
        chk("R8 dropped", {31'b0, irq_o}, 32'h0);

        // level line: R7 no ack, R4 guard, R8 re-raise, R3 release
        bus_wr(cfg_a(7), cfgw(0, 1'b1, 1'b0));
        bus_wr(A_MASK, 32'h0);
        src_i[7] = 1'b1; tick(2);
        chk("R5 level raise", {31'b0, irq_o}, 32'h1);
        bus_rd(A_CODE_N, 32'd7, "R6 level code");
        bus_rd(A_PEND, 32'h80, "R7 level kept");
        bus_wr(A_PEND, 32'h0);
        bus_rd(A_PEND, 32'h80, "R4 level guard");
        bus_wr(A_CTRL, 32'h1);
        chk("R8 drop", {31'b0, irq_o}, 32'h0);
        tick(1);
        chk("R8 re-raise", {31'b0, irq_o}, 32'h1);
        src_i[7] = 1'b0; tick(1);
        bus_rd(A_PEND, 32'h0, "R3 release");
        bus_wr(A_CTRL, 32'h1);
        tick(2);
        chk("R8 idle", {31'b0, irq_o}, 32'h0);

        // R6 tie to higher line, R4 AND on event lines
        src_i[1] = 1'b1; src_i[4] = 1'b1; tick(1);
        src_i[1] = 1'b0; src_i[4] = 1'b0; tick(1);
        bus_rd(A_CODE_N, 32'd4, "R6 tie");
        bus_rd(A_PEND, 32'h2, "R7 ack one");
        bus_wr(A_PEND, 32'h0);
        bus_rd(A_PEND, 32'h0, "R4 and");
        bus_wr(A_CTRL, 32'h1);
        tick(2);

        // R6 priority ordering
        bus_wr(cfg_a(10), cfgw(2, 1'b0, 1'b0));
        bus_wr(cfg_a(20), cfgw(1, 1'b0, 1'b0));
        bus_wr(cfg_a(0), cfgw(9, 1'b0, 1'b0));
        src_i[0] = 1'b1; src_i[10] = 1'b1; src_i[20] = 1'b1; tick(1);
        src_i[0] = 1'b0; src_i[10] = 1'b0; src_i[20] = 1'b0; tick(1);
        bus_rd(A_CODE_N, 32'd20, "R6 prio first");
        bus_wr(A_CTRL, 32'h1);
        tick(1);
        bus_rd(A_CODE_N, 32'd10, "R6 prio second");
        bus_wr(A_CTRL, 32'h1);
        tick(1);
        bus_rd(A_CODE_N, 32'd0, "R6 prio third");
        bus_wr(A_CTRL, 32'h1);
        tick(2);
        chk("R8 all served", {31'b0, irq_o}, 32'h0);

        // R5 fast class
        bus_wr(cfg_a(12), cfgw(0, 1'b0, 1'b1));
        src_i[12] = 1'b1; tick(1);
        src_i[12] = 1'b0; tick(1);
        chk("R5 fast raised", {31'b0, fiq_o}, 32'h1);
        chk("R5 normal quiet", {31'b0, irq_o}, 32'h0);
        bus_rd(A_CODE_F, 32'd12, "R6 fast code");
        bus_wr(A_CTRL, 32'h2);
        tick(1);
        chk("R8 fast drop", {31'b0, fiq_o}, 32'h0);

        // R11 read-only and unmapped
        bus_wr(A_CODE_F, 32'h1F);
        bus_rd(A_CODE_F, 32'd12, "R11 code read-only");
        bus_rd(8'h0C, 32'h0, "R11 unmapped");
        bus_rd(8'hA0, 32'h0, "R11 past end");
        bus_rd(8'h1A, 32'h0, "R11 misaligned");

        // R9 software trigger
        bus_wr(A_TRIG, 32'h00A0_0040);
        bus_rd(A_PEND, 32'h40, "R9 lowest only");
        bus_rd(A_CODE_N, 32'd6, "R9 raised line");
        bus_wr(A_TRIG, 32'h0);
        bus_rd(A_PEND, 32'h0, "R9 zero write");
        bus_wr(A_CTRL, 32'h1);
        tick(2);
        chk("R9 idle", {31'b0, irq_o}, 32'h0);

        tick(2);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule